// File: doc/BRIEF.md
# I2C Write-Only Slave Receiver

This block is the receive half of an I2C slave. It watches the open-drain SCL and SDA lines through two-flop synchronisers. It detects START and STOP conditions and shifts in the address byte that follows a START. When the 7-bit address equals the programmable own address, it raises an address-match flag and records the direction bit. For a write (direction bit 0) it acknowledges the address. It then collects data bytes MSB first into a one-byte receive buffer, acknowledging each one and raising a receive-ready flag.

Software reads the buffer with a single-cycle read strobe, and that strobe clears the receive-ready flag. A byte that completes while the buffer still holds unread data sets a sticky overrun flag. From then on the receiver answers every data byte with NACK and discards it, until software clears the overrun flag. STOP and repeated START do not clear it. A registered interrupt output combines the address-match and receive-ready flags, each gated by its own enable. The block drives SDA only, and only by pulling it low. It never stretches the clock.

Top module: `i2c_slave_rx`

## Requirements
- R1: After a synchronous reset, the following outputs are all 0: rx_ready, overrun, addr_match, xfer_mode, irq, sda_oe and rx_data.
- R2: After a START, the first 7 bits (MSB first, sampled on SCL rising) are compared with own_addr. On equality, addr_match is set and stays set until clr_match. On the same match, xfer_mode takes the 8th bit (R/W).
- R3: sda_oe is asserted during the 9th clock of the address byte only when the address matches and R/W is 0. Otherwise SDA is not driven, and data clocked before the next START is ignored (no ACK, rx_ready unchanged).
- R4: After an acknowledged address, each data byte is shifted in MSB first. If it is accepted, it is placed on rx_data, rx_ready is set, and the byte is acknowledged by pulling SDA low during its 9th clock.
- R5: A one-cycle rd_strobe clears rx_ready.
- R6: A data byte that completes while rx_ready is 1 (with no rd_strobe in that cycle) sets overrun. The byte is discarded, so rx_data keeps the earlier byte, and the byte is NACKed.
- R7: While overrun is 1, every data byte is NACKed and discarded, and rx_ready is not set. After clr_overrun, bytes are acknowledged and stored again.
- R8: A STOP (SDA rising while SCL is high) returns the receiver to idle but does not clear overrun. Bytes of a later transfer are still NACKed while overrun is 1.
- R9: irq equals (addr_match AND match_ie) OR (rx_ready AND rx_ie), registered one clock later.
- R10: A START (SDA falling while SCL is high) restarts address reception from any point, including partway through a data byte. After a STOP, data bytes are ignored until a new START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (ACK) |
| own_addr | input | 7 | Own slave address |
| rd_strobe | input | 1 | Buffer read strobe, clears rx_ready |
| clr_match | input | 1 | Clears addr_match |
| clr_overrun | input | 1 | Clears overrun |
| match_ie | input | 1 | Address-match interrupt enable |
| rx_ie | input | 1 | Receive-ready interrupt enable |
| rx_data | output | 8 | Receive buffer |
| rx_ready | output | 1 | Receive-ready flag |
| overrun | output | 1 | Overrun flag (sticky) |
| addr_match | output | 1 | Address-match flag |
| xfer_mode | output | 1 | R/W bit of the last matching address |
| irq | output | 1 | Interrupt request |

## Verification
Every one of the 128 addresses is sent as a write against one fixed own address. This shows that exactly one address is acknowledged and flagged, and that a near miss in any bit position is rejected. Every byte value from 0 to 255 is then received and read back, which separates correct MSB-first assembly from bit reversal or slip. Unread and read sequences separate the overrun trigger from the sticky NACK phase, and show the recovery after clearing. A STOP between transfers, a repeated START in the middle of a byte, and a read-direction address each check that the protocol resynchronises at the right points.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_AHOLD,
    ST_DATA,
    ST_DACK,
    ST_DHOLD
  } rx_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_pin,
  input  logic sda_pin,
  output logic sda_bit,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_pin};
      sda_sh <= {sda_sh[STAGES-2:0], sda_pin};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_bit   = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_bit;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_bit;
endmodule

// File: rtl/i2c_rx_fsm.sv
module i2c_rx_fsm
  import i2c_rx_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_bit,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              accept,
  output logic              addr_hit,
  output logic              rw_bit,
  output logic              byte_done,
  output logic [DATA_W-1:0] byte_val,
  output logic              sda_drive
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  rx_state_t         state;
  logic [DATA_W-2:0] shreg;
  logic [DATA_W-1:0] full;
  logic [CNT_W-1:0]  cnt;
  logic              ack_q;
  logic              last;

  assign full      = {shreg, sda_bit};
  assign last      = (cnt == LAST);
  assign rw_bit    = full[0];
  assign byte_val  = full;
  assign addr_hit  = (state == ST_ADDR) && scl_rise && last &&
                     (full[DATA_W-1 -: ADDR_W] == own_addr);
  assign byte_done = (state == ST_DATA) && scl_rise && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      shreg     <= '0;
      cnt       <= '0;
      ack_q     <= 1'b0;
      sda_drive <= 1'b0;
    end else if (start_det) begin
      state     <= ST_ADDR;
      cnt       <= '0;
      sda_drive <= 1'b0;
    end else if (stop_det) begin
      state     <= ST_IDLE;
      sda_drive <= 1'b0;
    end else begin
      case (state)
        ST_ADDR: if (scl_rise) begin
          shreg <= full[DATA_W-2:0];
          cnt   <= cnt + 1'b1;
          if (last) begin
            cnt   <= '0;
            state <= (addr_hit && !rw_bit) ? ST_AACK : ST_IDLE;
          end
        end
        ST_AACK: if (scl_fall) begin
          sda_drive <= 1'b1;
          state     <= ST_AHOLD;
        end
        ST_AHOLD: if (scl_fall) begin
          sda_drive <= 1'b0;
          cnt       <= '0;
          state     <= ST_DATA;
        end
        ST_DATA: if (scl_rise) begin
          shreg <= full[DATA_W-2:0];
          cnt   <= cnt + 1'b1;
          if (last) begin
            cnt   <= '0;
            ack_q <= accept;
            state <= ST_DACK;
          end
        end
        ST_DACK: if (scl_fall) begin
          sda_drive <= ack_q;
          state     <= ST_DHOLD;
        end
        ST_DHOLD: if (scl_fall) begin
          sda_drive <= 1'b0;
          cnt       <= '0;
          state     <= ST_DATA;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              rd_strobe,
  input  logic              clr_match,
  input  logic              clr_overrun,
  input  logic              match_ie,
  input  logic              rx_ie,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              overrun,
  output logic              addr_match,
  output logic              xfer_mode,
  output logic              irq
);
  logic              sda_bit, scl_rise, scl_fall, start_det, stop_det;
  logic              addr_hit, rw_bit, byte_done, accept;
  logic [DATA_W-1:0] byte_val;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_pin(scl_i), .sda_pin(sda_i),
    .sda_bit(sda_bit), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  // buffer has room when it is empty or is being read in this cycle
  assign accept = ~overrun & (~rx_ready | rd_strobe);

  i2c_rx_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .sda_bit(sda_bit), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .own_addr(own_addr), .accept(accept), .addr_hit(addr_hit),
    .rw_bit(rw_bit), .byte_done(byte_done), .byte_val(byte_val),
    .sda_drive(sda_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data    <= '0;
      rx_ready   <= 1'b0;
      overrun    <= 1'b0;
      addr_match <= 1'b0;
      xfer_mode  <= 1'b0;
      irq        <= 1'b0;
    end else begin
      if (addr_hit) begin
        addr_match <= 1'b1;
        xfer_mode  <= rw_bit;
      end else if (clr_match) begin
        addr_match <= 1'b0;
      end
      if (byte_done && accept) begin
        rx_data  <= byte_val;
        rx_ready <= 1'b1;
      end else if (rd_strobe) begin
        rx_ready <= 1'b0;
      end
      if (byte_done && !accept) overrun <= 1'b1;
      else if (clr_overrun)      overrun <= 1'b0;
      irq <= (addr_match & match_ie) | (rx_ready & rx_ie);
    end
  end
endmodule

// File: rtl/i2c_slave_rx_chk.sv
module i2c_slave_rx_chk (
  input logic clk,
  input logic rst,
  input logic rd_strobe,
  input logic clr_overrun,
  input logic match_ie,
  input logic rx_ie,
  input logic addr_hit,
  input logic byte_done,
  input logic rx_ready,
  input logic overrun,
  input logic addr_match,
  input logic sda_oe,
  input logic irq
);
  // R1: reset clears flags and the SDA driver
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!rx_ready && !overrun && !addr_match && !sda_oe && !irq));

  // R2: address hit leaves the match flag set
  assert_match_flag_R2: assert property (@(posedge clk) disable iff (rst)
    addr_hit |=> addr_match);

  // R5: read strobe with no new byte empties the buffer flag
  assert_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !byte_done) |=> !rx_ready);

  // R6: byte into a full buffer raises overrun
  assert_overrun_set_R6: assert property (@(posedge clk) disable iff (rst)
    (byte_done && rx_ready && !rd_strobe) |=> overrun);

  // R7: no byte is accepted while overrun is set
  assert_no_accept_R7: assert property (@(posedge clk) disable iff (rst)
    (overrun && byte_done && !rd_strobe) |=> $stable(rx_ready));

  // R8: overrun is sticky until cleared
  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (overrun && !clr_overrun) |=> overrun);

  // R9: interrupt follows gated flags one clock later
  assert_irq_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past((addr_match && match_ie) || (rx_ready && rx_ie))));
endmodule

bind i2c_slave_rx i2c_slave_rx_chk u_chk (
  .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .clr_overrun(clr_overrun),
  .match_ie(match_ie), .rx_ie(rx_ie), .addr_hit(addr_hit),
  .byte_done(byte_done), .rx_ready(rx_ready), .overrun(overrun),
  .addr_match(addr_match), .sda_oe(sda_oe), .irq(irq)
);

// File: tb/i2c_slave_rx_test.sv
`timescale 1ns/1ps
module i2c_slave_rx_test;
  localparam int Q = 8;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [6:0] own_addr = OWN;
  logic rd_strobe = 1'b0, clr_match = 1'b0, clr_overrun = 1'b0;
  logic match_ie = 1'b0, rx_ie = 1'b0;
  logic [7:0] rx_data;
  logic rx_ready, overrun, addr_match, xfer_mode, irq;
  logic sda_line;
  int tests = 0, fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_slave_rx uut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .own_addr(own_addr), .rd_strobe(rd_strobe), .clr_match(clr_match),
    .clr_overrun(clr_overrun), .match_ie(match_ie), .rx_ie(rx_ie),
    .rx_data(rx_data), .rx_ready(rx_ready), .overrun(overrun),
    .addr_match(addr_match), .xfer_mode(xfer_mode), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
    @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b, output logic got);
    sda_m = b; wq(); scl_m = 1'b1; wq(); got = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic g;
    for (int i = 7; i >= 0; i--) send_bit(b[i], g);
    send_bit(1'b1, g);
    acked = ~g;
  endtask

  initial begin
    logic ack;
    logic g;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 rx_ready", rx_ready, 0);
    check("R1 overrun", overrun, 0);
    check("R1 addr_match", addr_match, 0);
    check("R1 irq", irq, 0);
    check("R1 sda_oe", sda_oe, 0);
    check("R1 rx_data", rx_data, 0);

    // R2/R3: sweep all write addresses
    for (int a = 0; a < 128; a++) begin
      i2c_start();
      send_byte({a[6:0], 1'b0}, ack);
      check("R3 address ack", ack, (a == OWN) ? 1 : 0);
      check("R2 match flag", addr_match, (a == OWN) ? 1 : 0);
      if (a == OWN) check("R2 xfer_mode write", xfer_mode, 0);
      if (a == OWN + 1) begin
        send_byte(8'h5A, ack);
        check("R3 ignored data ack", ack, 0);
        check("R3 ignored data ready", rx_ready, 0);
      end
      i2c_stop();
      pulse(clr_match);
    end

    // R2/R3: read direction to own address
    i2c_start();
    send_byte({OWN, 1'b1}, ack);
    check("R3 read nack", ack, 0);
    check("R2 match on read", addr_match, 1);
    check("R2 xfer_mode read", xfer_mode, 1);
    i2c_stop();
    pulse(clr_match);

    // R4/R5/R9: every data value
    rx_ie = 1'b1;
    i2c_start();
    send_byte({OWN, 1'b0}, ack);
    for (int d = 0; d < 256; d++) begin
      send_byte(d[7:0], ack);
      check("R4 data ack", ack, 1);
      check("R4 rx_ready", rx_ready, 1);
      check("R4 rx_data", rx_data, d);
      if (d == 0) check("R9 irq on ready", irq, 1);
      pulse(rd_strobe);
      check("R5 read clears", rx_ready, 0);
      if (d == 0) check("R9 irq drops", irq, 0);
    end
    i2c_stop();

    // R9: match interrupt gating
    pulse(clr_match);
    match_ie = 1'b1;
    rx_ie = 1'b0;
    i2c_start();
    send_byte({OWN, 1'b0}, ack);
    check("R9 irq on match", irq, 1);
    pulse(clr_match);
    check("R9 irq after clear", irq, 0);
    send_byte(8'hC3, ack);
    check("R9 ready masked", irq, 0);
    match_ie = 1'b0;

    // R6/R7: overrun
    send_byte(8'h96, ack);
    check("R6 overrun nack", ack, 0);
    check("R6 overrun flag", overrun, 1);
    check("R6 buffer kept", rx_data, 8'hC3);
    send_byte(8'h11, ack);
    check("R7 nack while overrun", ack, 0);
    pulse(rd_strobe);
    send_byte(8'h22, ack);
    check("R7 nack after read", ack, 0);
    check("R7 no ready", rx_ready, 0);
    check("R7 buffer kept", rx_data, 8'hC3);
    i2c_stop();

    // R8: STOP keeps overrun
    check("R8 overrun after stop", overrun, 1);
    i2c_start();
    send_byte({OWN, 1'b0}, ack);
    check("R8 address still acked", ack, 1);
    send_byte(8'h33, ack);
    check("R8 nack next transfer", ack, 0);
    pulse(clr_overrun);
    check("R7 overrun cleared", overrun, 0);
    send_byte(8'hE7, ack);
    check("R7 ack resumes", ack, 1);
    check("R7 data resumes", rx_data, 8'hE7);
    pulse(rd_strobe);

    // R10: repeated START mid-byte
    send_bit(1'b1, g);
    send_bit(1'b0, g);
    send_bit(1'b1, g);
    i2c_start();
    send_byte({OWN, 1'b0}, ack);
    check("R10 restart address ack", ack, 1);
    send_byte(8'h3C, ack);
    check("R10 restart data ack", ack, 1);
    check("R10 restart data", rx_data, 8'h3C);
    pulse(rd_strobe);
    // R10: STOP mid-byte, following bytes ignored
    send_bit(1'b0, g);
    send_bit(1'b1, g);
    i2c_stop();
    scl_m = 1'b0; wq();
    send_byte(8'h81, ack);
    check("R10 ignored after stop", ack, 0);
    check("R10 no ready after stop", rx_ready, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule